// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Register

This block is the digital front end of a parallel-input, segmented digital-to-analog converter. A data word arrives on a parallel bus. An input register captures it under an active-low write strobe. A second register, the DAC register, then takes the input register contents under an active-high load strobe. The DAC register drives the converter core. Because the two stages are separate, many converters can be preloaded one by one and then updated together by one shared load strobe. Holding the write strobe low and the load strobe high makes both stages follow the bus. When the two strobes are tied together and pulsed low, one pulse performs a complete update.

A clear input, active low, forces both registers to a code chosen by a strap input: zero when the strap is 0, and midscale (only the top bit set) when it is 1. The clear input takes priority over both strobes. All strobe, clear, strap and data inputs pass through a two-flop alignment stage clocked by the system clock, so the bus and the strobes keep their relative timing. The output side has three parts: the DAC register word, 15 thermometer segment enables decoded from its top four bits, and the remaining low bits as binary switch controls. Both the segment enables and the switch controls are registered.

Top module: `dacbuf_top`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, both registers take the reset code selected by `mid_sel`. That code is zero for 0 and `1 << (DATA_W-1)` for 1.
- R2: The input register follows the aligned bus in every cycle in which the aligned write strobe is low, and holds its value while the strobe is high.
- R3: The DAC register copies the input register in every cycle in which the aligned load strobe is high, and holds its value while the load strobe is low.
- R4: With `wr_n` low and `ld` high, a bus value reaches `dac_q` four clock edges after it is applied: two alignment edges, then the input register, then the DAC register.
- R5: With `wr_n` high and `ld` low, bus changes have no effect on either register.
- R6: While the aligned `clr_n` is low, both registers are forced to the strap-selected code, whatever the strobes are doing.
- R7: When `wr_n` and `ld` are driven as one signal pulsed low, the DAC register receives the bus value present during the low phase. Bus changes after the rising edge are ignored.
- R8: Segment enable bit k-1, for k from 1 to 15, is high exactly when the top four bits of the DAC register are at least k. Top field 0 lights no segment and 15 lights all of them.
- R9: `bin_sw` equals the low `DATA_W-4` bits of the DAC register, and `seg_en` and `bin_sw` both lag `dac_q` by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write strobe for the input register |
| ld | input | 1 | Active-high load strobe for the DAC register |
| clr_n | input | 1 | Active-low clear to the strap code |
| mid_sel | input | 1 | Strap: 0 selects zero scale, 1 selects midscale |
| din | input | DATA_W | Parallel data word, straight binary, bit 0 is the LSB |
| dac_q | output | DATA_W | DAC register word |
| seg_en | output | 15 | Thermometer segment enables |
| bin_sw | output | DATA_W-4 | Binary-weighted switch controls |

## Verification
The bench sweeps every value of the four-bit segment field with several low-bit patterns. A decoder that is off by one, or that lights a segment for code zero, fails at the field ends. Bus changes are applied while the stage under test is holding, so a register that keeps loading when it should hold shows the later value. In the tied-strobe pulse, the bus changes both during the low phase and after the rising edge. A design that loads the DAC register too early, or keeps following the bus after the rise, delivers the wrong word. Clear is applied with each strap value and then released, followed by a bare load pulse. A design that clears only the DAC register reveals the old input register contents on that load.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;
  localparam int SEG_BITS = 4;
  localparam int SEG_NUM  = (1 << SEG_BITS) - 1;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_CLEAR,
    OP_LOAD_IN,
    OP_LOAD_DAC,
    OP_BOTH
  } reg_op_e;
endpackage

// File: rtl/dacbuf_align.sv
module dacbuf_align #(
  parameter int          WIDTH   = 8,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= RST_VAL;
        else     stage[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= RST_VAL;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dacbuf_regs.sv
module dacbuf_regs
  import dacbuf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_mid,
  input  logic              wr_s,
  input  logic              ld_s,
  input  logic              clr_s,
  input  logic              mid_s,
  input  logic [DATA_W-1:0] din_s,
  output logic [DATA_W-1:0] inp_q,
  output logic [DATA_W-1:0] dac_q
);
  localparam logic [DATA_W-1:0] CODE_MID  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] CODE_ZERO = '0;

  reg_op_e          op;
  logic [DATA_W-1:0] clr_code;
  logic [DATA_W-1:0] rst_code;

  assign clr_code = mid_s   ? CODE_MID : CODE_ZERO;
  assign rst_code = rst_mid ? CODE_MID : CODE_ZERO;

  always_comb begin
    if (!clr_s)               op = OP_CLEAR;
    else if (!wr_s && ld_s)   op = OP_BOTH;
    else if (!wr_s)           op = OP_LOAD_IN;
    else if (ld_s)            op = OP_LOAD_DAC;
    else                      op = OP_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inp_q <= rst_code;
      dac_q <= rst_code;
    end else begin
      case (op)
        OP_CLEAR: begin
          inp_q <= clr_code;
          dac_q <= clr_code;
        end
        OP_BOTH: begin
          inp_q <= din_s;
          dac_q <= inp_q;
        end
        OP_LOAD_IN:  inp_q <= din_s;
        OP_LOAD_DAC: dac_q <= inp_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dacbuf_seg.sv
module dacbuf_seg
  import dacbuf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W-1:0]        code,
  output logic [SEG_NUM-1:0]       seg_en,
  output logic [DATA_W-SEG_BITS-1:0] bin_sw
);
  localparam int BIN_W = DATA_W - SEG_BITS;

  logic [SEG_BITS-1:0] top;
  logic [SEG_NUM-1:0]  seg_d;

  assign top = code[DATA_W-1 -: SEG_BITS];

  for (genvar k = 1; k <= SEG_NUM; k++) begin : g_seg
    assign seg_d[k-1] = (top >= SEG_BITS'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_en <= '0;
      bin_sw <= '0;
    end else begin
      seg_en <= seg_d;
      bin_sw <= code[BIN_W-1:0];
    end
  end
endmodule

// File: rtl/dacbuf_top.sv
module dacbuf_top
  import dacbuf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_n,
  input  logic                       ld,
  input  logic                       clr_n,
  input  logic                       mid_sel,
  input  logic [DATA_W-1:0]          din,
  output logic [DATA_W-1:0]          dac_q,
  output logic [SEG_NUM-1:0]         seg_en,
  output logic [DATA_W-SEG_BITS-1:0] bin_sw
);
  localparam int ALN_W = DATA_W + 4;
  localparam logic [ALN_W-1:0] ALN_RST = {1'b1, 1'b0, 1'b1, 1'b0, {DATA_W{1'b0}}};

  logic [ALN_W-1:0]  aln_d;
  logic [ALN_W-1:0]  aln_q;
  logic              wr_s;
  logic              ld_s;
  logic              clr_s;
  logic              mid_s;
  logic [DATA_W-1:0] din_s;
  logic [DATA_W-1:0] inp_r;
  logic [DATA_W-1:0] dac_r;

  assign aln_d = {clr_n, mid_sel, wr_n, ld, din};
  assign {clr_s, mid_s, wr_s, ld_s, din_s} = aln_q;

  dacbuf_align #(
    .WIDTH  (ALN_W),
    .STAGES (2),
    .RST_VAL(ALN_RST)
  ) u_align (
    .clk(clk),
    .rst(rst),
    .d  (aln_d),
    .q  (aln_q)
  );

  dacbuf_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .rst_mid(mid_sel),
    .wr_s   (wr_s),
    .ld_s   (ld_s),
    .clr_s  (clr_s),
    .mid_s  (mid_s),
    .din_s  (din_s),
    .inp_q  (inp_r),
    .dac_q  (dac_r)
  );

  dacbuf_seg #(.DATA_W(DATA_W)) u_seg (
    .clk   (clk),
    .rst   (rst),
    .code  (dac_r),
    .seg_en(seg_en),
    .bin_sw(bin_sw)
  );

  assign dac_q = dac_r;
endmodule

// File: rtl/dacbuf_chk.sv
module dacbuf_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mid_sel,
  input logic              wr_s,
  input logic              ld_s,
  input logic              clr_s,
  input logic              mid_s,
  input logic [DATA_W-1:0] din_s,
  input logic [DATA_W-1:0] inp_r,
  input logic [DATA_W-1:0] dac_r,
  input logic [14:0]       seg_en,
  input logic [DATA_W-5:0] bin_sw
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic rst_q;
  logic mid_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    mid_q <= mid_sel;
  end

  // R1: the cycle after reset was applied the DAC register holds the strap code
  always_ff @(posedge clk) begin
    if (rst_q === 1'b1 && rst === 1'b1)
      a_r1_reset_code: assert (dac_r == (mid_q ? MID : '0));
  end

  a_r2_input_follows: assert property (@(posedge clk) disable iff (rst)
    (!rst && clr_s && !wr_s) |=> inp_r == $past(din_s));

  a_r3_dac_holds: assert property (@(posedge clk) disable iff (rst)
    (!rst && clr_s && !ld_s) |=> $stable(dac_r));

  a_r5_input_holds: assert property (@(posedge clk) disable iff (rst)
    (!rst && clr_s && wr_s) |=> $stable(inp_r));

  a_r6_clear_code: assert property (@(posedge clk) disable iff (rst)
    (!rst && !clr_s) |=> (dac_r == ($past(mid_s) ? MID : '0)) && (inp_r == dac_r));

  a_r8_seg_count: assert property (@(posedge clk) disable iff (rst)
    (rst_q == 1'b0) |-> $countones(seg_en) == int'($past(dac_r[DATA_W-1 -: 4])));

  a_r9_bin_lag: assert property (@(posedge clk) disable iff (rst)
    (rst_q == 1'b0) |-> bin_sw == $past(dac_r[DATA_W-5:0]));
endmodule

bind dacbuf_top dacbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .mid_sel(mid_sel),
  .wr_s   (wr_s),
  .ld_s   (ld_s),
  .clr_s  (clr_s),
  .mid_s  (mid_s),
  .din_s  (din_s),
  .inp_r  (inp_r),
  .dac_r  (dac_r),
  .seg_en (seg_en),
  .bin_sw (bin_sw)
);

// File: tb/dacbuf_top_bench.sv
module dacbuf_top_bench;
  localparam int W       = 16;
  localparam int CLK_T   = 10;
  localparam int WD_MAX  = 200000;
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_n = 1'b1;
  logic         ld = 1'b0;
  logic         clr_n = 1'b1;
  logic         mid_sel = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dac_q;
  logic [14:0]  seg_en;
  logic [W-5:0] bin_sw;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  always #(CLK_T/2) clk = ~clk;

  dacbuf_top #(.DATA_W(W)) u_dacbuf_top (
    .clk(clk), .rst(rst), .wr_n(wr_n), .ld(ld), .clr_n(clr_n),
    .mid_sel(mid_sel), .din(din), .dac_q(dac_q), .seg_en(seg_en), .bin_sw(bin_sw)
  );

  function automatic logic [14:0] therm(input logic [W-1:0] v);
    logic [14:0] t = '0;
    for (int k = 1; k <= 15; k++) t[k-1] = (int'(v[W-1 -: 4]) >= k);
    return t;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [W-1:0] exp);
    chk(req, 32'(dac_q), 32'(exp));
    chk({req, "/R8"}, 32'(seg_en), 32'(therm(exp)));
    chk({req, "/R9"}, 32'(bin_sw), 32'(exp[W-5:0]));
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic w, input logic l, input logic c, input logic [W-1:0] d);
    @(negedge clk);
    wr_n = w; ld = l; clr_n = c; din = d;
    settle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_MAX && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_MAX);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset with strap 0
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    settle();
    chk_all("R1 zero", '0);
    // R1: reset with strap 1
    @(negedge clk); rst = 1'b1; mid_sel = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    settle();
    chk_all("R1 mid", MID);
    mid_sel = 1'b0;

    // R4 / R8 / R9: transparent sweep over every segment field
    for (int t = 0; t < 16; t++) begin
      for (int p = 0; p < 3; p++) begin
        logic [W-1:0] v;
        v = {4'(t), (p == 0) ? 12'h000 : (p == 1) ? 12'hfff : 12'(12'h5a3 ^ (t * 37))};
        drive(1'b0, 1'b1, 1'b1, v);
        chk_all("R4 transparent", v);
      end
    end

    // R4: exact latency, dac changes at the fourth edge
    drive(1'b0, 1'b1, 1'b1, 16'h1234);
    @(negedge clk); din = 16'hbeef;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R4 before", 32'(dac_q), 32'h1234);
    @(posedge clk); @(negedge clk);
    chk("R4 at edge4", 32'(dac_q), 32'hbeef);

    // R5: both strobes inactive, bus ignored
    drive(1'b1, 1'b0, 1'b1, 16'hbeef);
    drive(1'b1, 1'b0, 1'b1, 16'h0f0f);
    chk_all("R5 idle", 16'hbeef);
    drive(1'b1, 1'b1, 1'b1, 16'h7777);
    chk_all("R5 input kept", 16'hbeef);

    // R2 / R3: preload input with DAC held, then load
    drive(1'b0, 1'b0, 1'b1, 16'h4321);
    drive(1'b0, 1'b0, 1'b1, 16'hc0de);
    chk_all("R3 held", 16'hbeef);
    drive(1'b1, 1'b0, 1'b1, 16'h0000);
    drive(1'b1, 1'b1, 1'b1, 16'hffff);
    chk_all("R2 last written", 16'hc0de);

    // R7: tied strobes pulsed low
    drive(1'b0, 1'b0, 1'b1, 16'h1111);
    chk_all("R7 low phase hold", 16'hc0de);
    drive(1'b0, 1'b0, 1'b1, 16'h2222);
    drive(1'b1, 1'b1, 1'b1, 16'h2222);
    chk_all("R7 after rise", 16'h2222);
    drive(1'b1, 1'b1, 1'b1, 16'h3333);
    chk_all("R7 post-rise bus", 16'h2222);

    // R6: clear overrides strobes, for each strap value
    for (int s = 0; s < 2; s++) begin
      logic [W-1:0] code;
      code = (s == 1) ? MID : '0;
      drive(1'b0, 1'b1, 1'b1, 16'h6a6a);
      @(negedge clk); mid_sel = 1'(s);
      drive(1'b0, 1'b1, 1'b0, 16'h9999);
      chk_all("R6 clear active", code);
      drive(1'b1, 1'b0, 1'b1, 16'h9999);
      chk_all("R6 released", code);
      drive(1'b1, 1'b1, 1'b1, 16'h9999);
      chk_all("R6 input cleared", code);
      @(negedge clk); ld = 1'b0;
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule